// File: doc/BRIEF.md
# Rate-2/3 Trellis Convolutional Encoder

This block turns a stream of 2-bit data words into 3-bit channel symbols, one symbol for every accepted word. The upper data bit is sent as-is, and the lower data bit passes through a feedback state machine made of two delay flip-flops. The 3-bit symbol picks one of eight constellation points. Its two low bits choose one of four subsets, and its top bit chooses one of the two parallel points inside that subset.

A source presents a word on `in_data` and raises `in_valid` for one clock. The encoder answers on the next clock with `out_valid` high and the symbol on `out_sym`. Strobes may arrive back to back or with gaps of any length, and the trellis state only moves when a word is accepted. Reset clears the state to zero, so a downstream decoder can begin its search from a known trellis state.

Top module: `trellis_enc23`

## Requirements
- R1: While `rst` is high, and on the first clock after it is sampled, `out_valid` is 0, `out_sym` is 3'b000 and both delay registers hold 0.
- R2: `out_valid` is high exactly one clock after each clock in which `in_valid` was high, and low otherwise.
- R3: Bit 2 of a valid `out_sym` equals bit 1 of the accepted `in_data` word.
- R4: Bit 1 of a valid `out_sym` is bit 0 of the accepted word XOR the second delay register, taken as it was before the word was accepted.
- R5: Bit 0 of a valid `out_sym` equals the first delay register, taken as it was before the word was accepted.
- R6: On an accepted word, the first delay register loads (second register XOR `in_data[0]`) and the second delay register loads the old first register.
- R7: A clock with `in_valid` low changes neither the delay registers nor `out_sym`.
- R8: A reset asserted in the middle of a stream discards the trellis state, so the first word after it is coded from state zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data word strobe |
| in_data | input | 2 | Data word; bit 1 uncoded, bit 0 coded |
| out_valid | output | 1 | Symbol strobe, one clock after `in_valid` |
| out_sym | output | 3 | Channel symbol; bits 1:0 subset, bit 2 point in subset |

## Verification
A wrong delay-register value cannot be seen on the symbol that is being coded at that moment. It appears in bit 0 of the next valid symbol, and in bit 1 the symbol after that. A state fault therefore reaches the ports within two accepted words, and it keeps reappearing until a reset clears it. Faults in the gating, such as the state moving during a gap or a reset that is ignored, show up as a wrong low bit on the first symbol after the gap or after the reset.

// File: rtl/trellis_enc23_pkg.sv
package trellis_enc23_pkg;
  localparam int unsigned WORD_W = 2;
  localparam int unsigned SYM_W  = WORD_W + 1;
  localparam int unsigned REG_N  = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SYM_W-1:0]  sym_t;

  typedef struct packed {
    logic d2;
    logic d1;
  } tstate_t;
endpackage

// File: rtl/trellis_enc23_state.sv
module trellis_enc23_state
  import trellis_enc23_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    adv,
  input  logic    coded_bit,
  output tstate_t st_q
);
  tstate_t st_d;

  always_comb begin
    st_d = st_q;
    if (adv) begin
      st_d.d1 = st_q.d2 ^ coded_bit;
      st_d.d2 = st_q.d1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  // R6: register shift on an accepted word
  a_r6_shift: assert property (@(posedge clk) disable iff (rst)
    adv |=> (st_q.d2 == $past(st_q.d1)));
  a_r6_feedback: assert property (@(posedge clk) disable iff (rst)
    adv |=> (st_q.d1 == ($past(st_q.d2) ^ $past(coded_bit))));
  // R7: no movement during a gap
  a_r7_state_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(st_q));
endmodule

// File: rtl/trellis_enc23_symreg.sv
module trellis_enc23_symreg
  import trellis_enc23_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  word_t   word,
  input  tstate_t st,
  output logic    sym_valid,
  output sym_t    sym_q
);
  sym_t sym_d;

  always_comb begin
    sym_d[SYM_W-1] = word[WORD_W-1];
    sym_d[1]       = word[0] ^ st.d2;
    sym_d[0]       = st.d1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_valid <= 1'b0;
      sym_q     <= '0;
    end else begin
      sym_valid <= load;
      if (load) sym_q <= sym_d;
    end
  end

  // R2: strobe latency of one clock
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    load |=> sym_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !load |=> !sym_valid);
  // R3: uncoded bit passes through
  a_r3_uncoded: assert property (@(posedge clk) disable iff (rst)
    load |=> (sym_q[SYM_W-1] == $past(word[WORD_W-1])));
  // R7: symbol held during a gap
  a_r7_sym_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(sym_q));
endmodule

// File: rtl/trellis_enc23.sv
module trellis_enc23
  import trellis_enc23_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_data,
  output logic             out_valid,
  output logic [2:0]       out_sym
);
  tstate_t st;

  trellis_enc23_state u_state (
    .clk       (clk),
    .rst       (rst),
    .adv       (in_valid),
    .coded_bit (in_data[0]),
    .st_q      (st)
  );

  trellis_enc23_symreg u_sym (
    .clk       (clk),
    .rst       (rst),
    .load      (in_valid),
    .word      (in_data),
    .st        (st),
    .sym_valid (out_valid),
    .sym_q     (out_sym)
  );

  // R1: clean state after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_sym == '0 && st == '0));
  // R5: low symbol bit tracks the first register across a valid word
  a_r5_low_bit: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_sym[0] == $past(st.d1)));
endmodule

// File: tb/tb_trellis_enc23.sv
module tb_trellis_enc23;
  localparam int CLK_P    = 10;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_data = 2'b00;
  logic       out_valid;
  logic [2:0] out_sym;

  int vectors = 0;
  int misses  = 0;

  int m_d1 = 0, m_d2 = 0;
  int e_valid = 0, e_sym = 0;
  bit e_after_rst = 1'b1;
  string tag_pref = "";

  trellis_enc23 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_sym(out_sym)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_now();
    if (e_after_rst) begin
      chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      chk(int'(out_sym) == 0, "R1 symbol after reset", int'(out_sym), 0);
    end else begin
      chk(int'(out_valid) == e_valid, "R2 valid latency", int'(out_valid), e_valid);
      if (e_valid != 0) begin
        chk(int'(out_sym[2]) == ((e_sym >> 2) & 1), {tag_pref, "R3 uncoded bit"},
            int'(out_sym[2]), (e_sym >> 2) & 1);
        chk(int'(out_sym[1]) == ((e_sym >> 1) & 1), {tag_pref, "R4,R6 coded bit"},
            int'(out_sym[1]), (e_sym >> 1) & 1);
        chk(int'(out_sym[0]) == (e_sym & 1), {tag_pref, "R5,R6 state bit"},
            int'(out_sym[0]), e_sym & 1);
      end else begin
        chk(int'(out_sym) == e_sym, "R7 symbol held in gap", int'(out_sym), e_sym);
      end
    end
  endtask

  task automatic step(input bit r, input bit v, input logic [1:0] d, input string pref = "");
    int t;
    @(negedge clk);
    check_now();
    rst = r; in_valid = v; in_data = d;
    tag_pref = pref;
    e_after_rst = r;
    if (r) begin
      m_d1 = 0; m_d2 = 0; e_valid = 0; e_sym = 0;
    end else begin
      e_valid = v ? 1 : 0;
      if (v) begin
        e_sym = (int'(d[1]) << 2) | ((int'(d[0]) ^ m_d2) << 1) | m_d1;
        t = m_d1;
        m_d1 = m_d2 ^ int'(d[0]);
        m_d2 = t;
      end
    end
  endtask

  initial begin
    step(1'b1, 1'b0, 2'b00);
    step(1'b1, 1'b1, 2'b11);
    // directed walk through the trellis
    step(1'b0, 1'b1, 2'b01);
    step(1'b0, 1'b1, 2'b10);
    step(1'b0, 1'b1, 2'b00);
    step(1'b0, 1'b1, 2'b11);
    // gap: R7, state must not move
    step(1'b0, 1'b0, 2'b11);
    step(1'b0, 1'b0, 2'b01);
    step(1'b0, 1'b1, 2'b01);
    // random back-to-back and gapped traffic
    for (int i = 0; i < 400; i++) begin
      step(1'b0, ($urandom % 3) != 0, 2'($urandom));
    end
    // R8: mid-stream reset, then first word coded from state zero
    step(1'b0, 1'b1, 2'b01);
    step(1'b1, 1'b1, 2'b11);
    step(1'b0, 1'b1, 2'b01, "R8 ");
    step(1'b0, 1'b1, 2'b11, "R8 ");
    for (int i = 0; i < 200; i++) begin
      step(($urandom % 50) == 0, ($urandom % 2) != 0, 2'($urandom));
    end
    step(1'b0, 1'b0, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule